// File: doc/BRIEF.md
# Adaptive Route Port Selector

This block makes the per-packet forwarding decision for one 8-input, 8-output element of a bidirectional multistage switching network. Each input lane presents a header that carries up to four permitted output ports with a permission mask, plus a flag that says whether the packet is now travelling downward, away from the turn-around switch. The block also sees a busy flag and a queued-flit load count for every output port.

While travelling upward, a packet may leave by any permitted port, and the block picks the least-loaded idle one. While travelling downward, only the single port in slot 0 is legal. If the chosen path is free, the packet is granted cut-through straight to the output. If it is blocked, or if it loses to another input that wants the same idle output in the same cycle, the block tells the central buffer to park the packet on that port's queue. A header with no usable permission is flagged as an error and is not forwarded.

Every decision is registered, so each lane's verdict appears one clock after its header.

Top module: `route_port_selector`

## Requirements
- R1: While `rst_n` is low, every `dec_*` output is zero.
- R2: `dec_valid[i]` equals `hdr_valid[i]` of the previous cycle. A lane with no valid header reports pass, park and error as 0 and port 0.
- R3: Upward hop (`hdr_down[i]`=0). Consider the slots whose mask bit is set and whose port is idle (`out_busy`=0). The block selects the one whose port has the smallest `out_load`, with a tie going to the lower port number. Cleared slots are ignored even if their load is lower. Unless R8 applies, the verdict is pass.
- R4: Upward hop in which every permitted port is busy. The verdict is park, on the least-loaded permitted port, with a tie going to the lower port number.
- R5: Downward hop (`hdr_down[i]`=1). Only slot 0 (`hdr_ports[i*12 +: 3]`) is used. The verdict is pass on that port if it is idle and park on it if it is busy. Other slots and all loads have no effect.
- R6: An upward header with mask 0, or a downward header with mask bit 0 clear, gives error=1, pass=0, park=0 and port 0.
- R7: Every valid verdict has exactly one of pass, park or error set.
- R8: When several inputs select the same idle port in one cycle, one of them passes and the others park on that port. Each output keeps a round-robin pointer that starts at input 0. The winner is the first requesting input at or after the pointer, counting upward with wrap-around. After a grant, the pointer moves to the winner plus one.
- R9: No two lanes pass to the same output port in the same cycle.
- R10: A pass verdict only names a port that was idle in the header's cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 8 | Header present on lane i |
| hdr_down | input | 8 | Lane i is on a downward (deterministic) hop |
| hdr_mask | input | 32 | Bit i*4+s permits slot s of lane i |
| hdr_ports | input | 96 | Port number of slot s of lane i at bits (i*4+s)*3 +: 3 |
| out_busy | input | 8 | Output port p currently transmitting |
| out_load | input | 64 | Queued flits for port p at bits p*8 +: 8 |
| dec_valid | output | 8 | Verdict present for lane i |
| dec_pass | output | 8 | Lane i granted cut-through |
| dec_park | output | 8 | Lane i to be written into the central buffer |
| dec_err | output | 8 | Lane i header unusable, not forwarded |
| dec_port | output | 24 | Selected port of lane i at bits i*3 +: 3 |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle relation between header and verdict;
- that each verdict has exactly one outcome;
- that no output is passed to twice;
- that a pass names a port that was idle;
- the error condition on the mask;
- the fixed slot-0 port on downward hops.

Only the bench's scenarios show which port is chosen. This covers least-load selection with ties broken by port number, and that masked slots are ignored. It also covers the parking target when every candidate is busy, and the rotating grant order among inputs that contend for one port over several cycles.

// File: rtl/rps_pkg.sv
package rps_pkg;
    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_PASS = 2'd1,
        VERDICT_PARK = 2'd2,
        VERDICT_ERR  = 2'd3
    } verdict_e;
endpackage

// File: rtl/rps_cand_pick.sv
// Per-lane candidate selection: least-loaded idle port among permitted slots,
// with fallback to least-loaded permitted port when all are busy.
module rps_cand_pick #(
    parameter int NUM_OUT  = 8,
    parameter int NUM_CAND = 4,
    parameter int LOAD_W   = 8,
    localparam int PW      = $clog2(NUM_OUT)
) (
    input  logic                     down,
    input  logic [NUM_CAND-1:0]      mask,
    input  logic [NUM_CAND*PW-1:0]   ports,
    input  logic [NUM_OUT-1:0]       busy,
    input  logic [NUM_OUT*LOAD_W-1:0] load,
    output logic                     err,
    output logic                     idle_hit,
    output logic [PW-1:0]            port
);
    logic [PW-1:0]     slot_p [NUM_CAND];
    logic [LOAD_W-1:0] slot_l [NUM_CAND];
    logic              slot_idle [NUM_CAND];

    for (genvar s = 0; s < NUM_CAND; s++) begin : g_slot
        assign slot_p[s]    = ports[s*PW +: PW];
        assign slot_l[s]    = load[slot_p[s]*LOAD_W +: LOAD_W];
        assign slot_idle[s] = !busy[slot_p[s]];
    end

    logic              any_ok, idle_ok;
    logic [PW-1:0]     best_all_p, best_idle_p;
    logic [LOAD_W-1:0] best_all_l, best_idle_l;

    always_comb begin
        any_ok      = 1'b0;
        idle_ok     = 1'b0;
        best_all_p  = '0;
        best_idle_p = '0;
        best_all_l  = '0;
        best_idle_l = '0;
        for (int s = 0; s < NUM_CAND; s++) begin
            if (mask[s]) begin
                if (!any_ok || slot_l[s] < best_all_l ||
                    (slot_l[s] == best_all_l && slot_p[s] < best_all_p)) begin
                    best_all_p = slot_p[s];
                    best_all_l = slot_l[s];
                end
                any_ok = 1'b1;
                if (slot_idle[s]) begin
                    if (!idle_ok || slot_l[s] < best_idle_l ||
                        (slot_l[s] == best_idle_l && slot_p[s] < best_idle_p)) begin
                        best_idle_p = slot_p[s];
                        best_idle_l = slot_l[s];
                    end
                    idle_ok = 1'b1;
                end
            end
        end

        if (down) begin
            err      = !mask[0];
            idle_hit = mask[0] && slot_idle[0];
            port     = mask[0] ? slot_p[0] : '0;
        end else begin
            err      = !any_ok;
            idle_hit = idle_ok;
            port     = idle_ok ? best_idle_p : best_all_p;
        end
    end
endmodule

// File: rtl/rps_rr_arb.sv
// Round-robin grant among inputs requesting one output port.
module rps_rr_arb #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] win,
    output logic          any
);
    always_comb begin
        gnt = '0;
        win = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!any && req[idx]) begin
                any      = 1'b1;
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/route_port_selector.sv
module route_port_selector #(
    parameter int NUM_IN   = 8,
    parameter int NUM_OUT  = 8,
    parameter int NUM_CAND = 4,
    parameter int LOAD_W   = 8,
    localparam int PW      = $clog2(NUM_OUT),
    localparam int IW      = $clog2(NUM_IN)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             hdr_valid,
    input  logic [NUM_IN-1:0]             hdr_down,
    input  logic [NUM_IN*NUM_CAND-1:0]    hdr_mask,
    input  logic [NUM_IN*NUM_CAND*PW-1:0] hdr_ports,
    input  logic [NUM_OUT-1:0]            out_busy,
    input  logic [NUM_OUT*LOAD_W-1:0]     out_load,
    output logic [NUM_IN-1:0]             dec_valid,
    output logic [NUM_IN-1:0]             dec_pass,
    output logic [NUM_IN-1:0]             dec_park,
    output logic [NUM_IN-1:0]             dec_err,
    output logic [NUM_IN*PW-1:0]          dec_port
);
    import rps_pkg::*;

    typedef struct packed {
        logic [NUM_IN-1:0]    vld;
        logic [NUM_IN-1:0]    pass;
        logic [NUM_IN-1:0]    park;
        logic [NUM_IN-1:0]    err;
        logic [NUM_IN*PW-1:0] port;
        logic [NUM_OUT*IW-1:0] ptr;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_IN-1:0] pk_err, pk_idle;
    logic [PW-1:0]     pk_port [NUM_IN];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_pick
        rps_cand_pick #(
            .NUM_OUT (NUM_OUT),
            .NUM_CAND(NUM_CAND),
            .LOAD_W  (LOAD_W)
        ) u_pick (
            .down    (hdr_down[i]),
            .mask    (hdr_mask[i*NUM_CAND +: NUM_CAND]),
            .ports   (hdr_ports[i*NUM_CAND*PW +: NUM_CAND*PW]),
            .busy    (out_busy),
            .load    (out_load),
            .err     (pk_err[i]),
            .idle_hit(pk_idle[i]),
            .port    (pk_port[i])
        );
    end

    logic [NUM_OUT-1:0][NUM_IN-1:0] req_mat, gnt_mat;
    logic [IW-1:0]                  arb_win [NUM_OUT];
    logic [NUM_OUT-1:0]             arb_any;

    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                req_mat[o][i] = hdr_valid[i] && !pk_err[i] && pk_idle[i] &&
                                (int'(pk_port[i]) == o);
            end
        end
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_arb
        rps_rr_arb #(.N(NUM_IN)) u_arb (
            .req(req_mat[o]),
            .ptr(state_q.ptr[o*IW +: IW]),
            .gnt(gnt_mat[o]),
            .win(arb_win[o]),
            .any(arb_any[o])
        );
    end

    verdict_e verdict [NUM_IN];

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_IN; i++) begin
            logic won;
            won = 1'b0;
            for (int o = 0; o < NUM_OUT; o++) begin
                won = won | gnt_mat[o][i];
            end
            if (!hdr_valid[i])    verdict[i] = VERDICT_NONE;
            else if (pk_err[i])   verdict[i] = VERDICT_ERR;
            else if (won)         verdict[i] = VERDICT_PASS;
            else                  verdict[i] = VERDICT_PARK;

            state_d.vld[i]  = hdr_valid[i];
            state_d.pass[i] = (verdict[i] == VERDICT_PASS);
            state_d.park[i] = (verdict[i] == VERDICT_PARK);
            state_d.err[i]  = (verdict[i] == VERDICT_ERR);
            state_d.port[i*PW +: PW] =
                (verdict[i] == VERDICT_PASS || verdict[i] == VERDICT_PARK) ? pk_port[i] : '0;
        end
        for (int o = 0; o < NUM_OUT; o++) begin
            if (arb_any[o]) begin
                state_d.ptr[o*IW +: IW] = IW'((int'(arb_win[o]) + 1) % NUM_IN);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dec_valid = state_q.vld;
    assign dec_pass  = state_q.pass;
    assign dec_park  = state_q.park;
    assign dec_err   = state_q.err;
    assign dec_port  = state_q.port;
endmodule

// File: rtl/rps_checks.sv
module rps_checks #(
    parameter int NUM_IN   = 8,
    parameter int NUM_OUT  = 8,
    parameter int NUM_CAND = 4,
    parameter int LOAD_W   = 8,
    localparam int PW      = $clog2(NUM_OUT)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_IN-1:0]             hdr_valid,
    input logic [NUM_IN-1:0]             hdr_down,
    input logic [NUM_IN*NUM_CAND-1:0]    hdr_mask,
    input logic [NUM_IN*NUM_CAND*PW-1:0] hdr_ports,
    input logic [NUM_OUT-1:0]            out_busy,
    input logic [NUM_OUT*LOAD_W-1:0]     out_load,
    input logic [NUM_IN-1:0]             dec_valid,
    input logic [NUM_IN-1:0]             dec_pass,
    input logic [NUM_IN-1:0]             dec_park,
    input logic [NUM_IN-1:0]             dec_err,
    input logic [NUM_IN*PW-1:0]          dec_port
);
    logic [NUM_OUT-1:0] busy_q;
    always_ff @(posedge clk) busy_q <= out_busy;

    logic [NUM_IN-1:0] pass_on [NUM_OUT];
    always_comb begin
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int i = 0; i < NUM_IN; i++) begin
                pass_on[o][i] = dec_pass[i] && (int'(dec_port[i*PW +: PW]) == o);
            end
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
        assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
            hdr_valid[i] |=> dec_valid[i]);
        assert_idle_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !hdr_valid[i] |=> !dec_valid[i] && !dec_pass[i] && !dec_park[i] && !dec_err[i]);
        assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
            dec_valid[i] |-> $countones({dec_pass[i], dec_park[i], dec_err[i]}) == 1);
        assert_pass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
            dec_pass[i] |-> !busy_q[dec_port[i*PW +: PW]]);
        assert_err_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            hdr_valid[i] |=> (dec_err[i] == ($past(hdr_down[i]) ?
                                 !$past(hdr_mask[i*NUM_CAND]) :
                                 ($past(hdr_mask[i*NUM_CAND +: NUM_CAND]) == '0))));
        assert_down_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hdr_valid[i] && hdr_down[i] && hdr_mask[i*NUM_CAND] |=>
                dec_port[i*PW +: PW] == $past(hdr_ports[i*NUM_CAND*PW +: PW]));
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        assert_single_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pass_on[o]));
    end
endmodule

bind route_port_selector rps_checks #(
    .NUM_IN  (NUM_IN),
    .NUM_OUT (NUM_OUT),
    .NUM_CAND(NUM_CAND),
    .LOAD_W  (LOAD_W)
) u_rps_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_valid(hdr_valid),
    .hdr_down (hdr_down),
    .hdr_mask (hdr_mask),
    .hdr_ports(hdr_ports),
    .out_busy (out_busy),
    .out_load (out_load),
    .dec_valid(dec_valid),
    .dec_pass (dec_pass),
    .dec_park (dec_park),
    .dec_err  (dec_err),
    .dec_port (dec_port)
);

// File: tb/route_port_selector_bench.sv
module route_port_selector_bench;
    localparam int NI = 8, NO = 8, NC = 4, LW = 8, PW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     hdr_valid = '0;
    logic [NI-1:0]     hdr_down = '0;
    logic [NI*NC-1:0]  hdr_mask = '0;
    logic [NI*NC*PW-1:0] hdr_ports = '0;
    logic [NO-1:0]     out_busy = '0;
    logic [NO*LW-1:0]  out_load = '0;
    logic [NI-1:0]     dec_valid, dec_pass, dec_park, dec_err;
    logic [NI*PW-1:0]  dec_port;

    route_port_selector u_route_port_selector (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_down(hdr_down), .hdr_mask(hdr_mask),
        .hdr_ports(hdr_ports), .out_busy(out_busy), .out_load(out_load),
        .dec_valid(dec_valid), .dec_pass(dec_pass), .dec_park(dec_park),
        .dec_err(dec_err), .dec_port(dec_port)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [NI-1:0]    v, pa, pk, er;
        logic [NI*PW-1:0] port;
        logic [NI*4-1:0]  tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fails = 0;
    bit   finished = 0;

    bit         b_valid [NI];
    bit         b_down  [NI];
    bit [NC-1:0] b_mask [NI];
    bit [PW-1:0] b_port [NI][NC];
    bit [NO-1:0] b_busy;
    bit [LW-1:0] b_load [NO];
    int          rr_ptr [NO];

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic clr();
        for (int i = 0; i < NI; i++) begin
            b_valid[i] = 0; b_down[i] = 0; b_mask[i] = '0;
            for (int s = 0; s < NC; s++) b_port[i][s] = '0;
        end
        b_busy = '0;
        for (int p = 0; p < NO; p++) b_load[p] = '0;
    endtask

    task automatic model(int i, output bit err, output bit idle, output int port);
        bit any_ok = 0, idle_ok = 0;
        int ba = 0, bi = 0;
        err = 0; idle = 0; port = 0;
        if (b_down[i]) begin
            err  = !b_mask[i][0];
            idle = b_mask[i][0] && !b_busy[b_port[i][0]];
            port = err ? 0 : int'(b_port[i][0]);
            return;
        end
        for (int s = 0; s < NC; s++) begin
            int p;
            p = int'(b_port[i][s]);
            if (b_mask[i][s]) begin
                if (!any_ok || b_load[p] < b_load[ba] || (b_load[p] == b_load[ba] && p < ba)) ba = p;
                any_ok = 1;
                if (!b_busy[p]) begin
                    if (!idle_ok || b_load[p] < b_load[bi] || (b_load[p] == b_load[bi] && p < bi)) bi = p;
                    idle_ok = 1;
                end
            end
        end
        err  = !any_ok;
        idle = idle_ok;
        port = idle_ok ? bi : ba;
    endtask

    task automatic apply();
        exp_t e;
        bit   l_err [NI];
        bit   l_idle [NI];
        int   l_port [NI];
        bit   l_won [NI];
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            hdr_valid[i] = b_valid[i];
            hdr_down[i]  = b_down[i];
            hdr_mask[i*NC +: NC] = b_mask[i];
            for (int s = 0; s < NC; s++) hdr_ports[(i*NC+s)*PW +: PW] = b_port[i][s];
        end
        out_busy = b_busy;
        for (int p = 0; p < NO; p++) out_load[p*LW +: LW] = b_load[p];

        e.v = '0; e.pa = '0; e.pk = '0; e.er = '0; e.port = '0; e.tag = '0;
        for (int i = 0; i < NI; i++) begin
            model(i, l_err[i], l_idle[i], l_port[i]);
            l_won[i] = 0;
        end
        for (int o = 0; o < NO; o++) begin
            int nreq = 0;
            for (int i = 0; i < NI; i++)
                if (b_valid[i] && !l_err[i] && l_idle[i] && l_port[i] == o) nreq++;
            for (int k = 0; k < NI; k++) begin
                int idx;
                idx = (rr_ptr[o] + k) % NI;
                if (b_valid[idx] && !l_err[idx] && l_idle[idx] && l_port[idx] == o) begin
                    l_won[idx] = 1;
                    rr_ptr[o] = (idx + 1) % NI;
                    break;
                end
            end
            for (int i = 0; i < NI; i++)
                if (nreq > 1 && b_valid[i] && !l_err[i] && l_port[i] == o) e.tag[i*4 +: 4] = 4'd8;
        end
        for (int i = 0; i < NI; i++) begin
            if (!b_valid[i]) begin
                e.tag[i*4 +: 4] = 4'd2;
                continue;
            end
            e.v[i] = 1;
            if (l_err[i]) begin
                e.er[i] = 1; e.tag[i*4 +: 4] = 4'd6;
                continue;
            end
            e.pa[i] = l_won[i];
            e.pk[i] = !l_won[i];
            e.port[i*PW +: PW] = PW'(l_port[i]);
            if (e.tag[i*4 +: 4] != 4'd8)
                e.tag[i*4 +: 4] = b_down[i] ? 4'd5 : (l_won[i] ? 4'd3 : 4'd4);
        end
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (rst_n && !finished) begin
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                for (int i = 0; i < NI; i++) begin
                    logic [6:0] act, expv;
                    act  = {dec_valid[i], dec_pass[i], dec_park[i], dec_err[i], dec_port[i*PW +: PW]};
                    expv = {e.v[i], e.pa[i], e.pk[i], e.er[i], e.port[i*PW +: PW]};
                    n_checks++;
                    if (act !== expv) begin
                        n_fails++;
                        $display("FAIL %s lane %0d: actual v/pass/park/err/port=%b expected %b",
                                 tag_name(int'(e.tag[i*4 +: 4])), i, act, expv);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual run not finished, expected completion");
        finish_run();
    end

    initial begin
        for (int o = 0; o < NO; o++) rr_ptr[o] = 0;
        clr();
        hdr_valid = '1; hdr_mask = '1; out_load = '1;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset despite active headers
        n_checks++;
        if ({dec_valid, dec_pass, dec_park, dec_err, dec_port} !== '0) begin
            n_fails++;
            $display("FAIL R1: actual %h expected 0", {dec_valid, dec_pass, dec_park, dec_err, dec_port});
        end
        hdr_valid = '0; hdr_mask = '0; out_load = '0;
        rst_n = 1'b1;

        // R2: idle cycles
        apply(); apply();

        // R3: least load, tie to lower port
        clr();
        b_valid[0] = 1; b_mask[0] = 4'b1111;
        b_port[0][0] = 2; b_port[0][1] = 5; b_port[0][2] = 1; b_port[0][3] = 7;
        b_load[2] = 9; b_load[5] = 4; b_load[1] = 6; b_load[7] = 4;
        apply();                          // expect pass on 5
        b_mask[0] = 4'b1101; apply();     // slot 1 masked: pass on 7
        b_busy[7] = 1; apply();           // 7 busy: pass on 1 despite higher load
        // R4: all permitted busy -> park on least loaded
        b_busy = 8'hFF; apply();          // park on 7
        b_load[7] = 6; apply();           // tie 1 and 7 at 6: park on 1

        // R5: downward uses slot 0 only
        clr();
        b_valid[3] = 1; b_down[3] = 1; b_mask[3] = 4'b1111;
        b_port[3][0] = 4; b_port[3][1] = 0; b_port[3][2] = 6;
        b_load[4] = 50;
        apply();                          // pass 4
        b_busy[4] = 1; apply();           // park 4
        // R6: errors
        b_mask[3] = 4'b1110; apply();     // downward without slot 0
        b_valid[6] = 1; b_mask[6] = 4'b0000; b_port[6][0] = 2; apply();

        // R8: three lanes contend for port 3 over several cycles
        clr();
        foreach (b_valid[i]) ;
        b_valid[1] = 1; b_valid[4] = 1; b_valid[6] = 1;
        b_mask[1] = 4'b0001; b_mask[4] = 4'b0010; b_mask[6] = 4'b1000;
        b_port[1][0] = 3; b_port[4][1] = 3; b_port[6][3] = 3;
        repeat (5) apply();
        clr(); apply();

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < NI; i++) begin
                b_valid[i] = ($urandom % 4) != 0;
                b_down[i]  = ($urandom % 4) == 0;
                b_mask[i]  = NC'($urandom % 16);
                for (int s = 0; s < NC; s++) b_port[i][s] = PW'($urandom % NO);
            end
            b_busy = NO'($urandom & $urandom);
            for (int p = 0; p < NO; p++) b_load[p] = LW'($urandom % 8);
            apply();
        end
        clr(); apply();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule